// File: doc/BRIEF.md
# Configurable SPI Master Controller

The block runs one SPI frame for each accepted start request. It produces the serial clock, drives the outgoing data line, samples the incoming data line and can sequence an active-low chip select. Before each frame it takes a set of configuration inputs and holds them until the frame ends. These inputs choose:

- the line direction: both ways, transmit-only or receive-only;
- an 8-bit or 16-bit frame;
- the order in which bits leave and arrive;
- a power-of-two clock divider;
- the clock polarity and phase;
- whether the block owns chip select.

A parallel word goes in when the start request is accepted. A parallel word comes back when the done pulse fires. Busy stays high for the whole frame.

The half-period of the serial clock is 2^n system clocks, where n is the 3-bit divider code. The division ratio is therefore 2^(n+1), which spans 2 to 256. A frame has three stretches in a fixed order, each measured in half-periods:

1. a lead-in with chip select low and the clock at its idle level;
2. twice as many clock edges as there are data bits;
3. one trailing half-period before chip select rises and done fires.

Top module: `spi_xfer_master`

## Requirements
- R1: Consecutive serial clock edges within a frame are exactly 2^div_code_i system clocks apart.
- R2: sclk_o rests at the polarity latched for the last frame while idle, and it is back at that level after the final edge. With polarity 0 the first edge rises; with polarity 1 it falls.
- R3: A frame makes exactly 16 clock edges when wide_i=0 (8 bits) and 32 edges when wide_i=1 (16 bits).
- R4: In full-duplex (dir_i=0) and transmit-only (dir_i=1), the bits of tx_data_i appear on mosi_o at the sample edges. With lsb_first_i=0 the order is from the top bit of the frame down to bit 0; with lsb_first_i=1 it is from bit 0 up. With cpha_i=0, bit 0 of the sequence is already valid before the first edge.
- R5: miso_i is captured on odd edges (1st, 3rd, ...) when cpha_i=0 and on even edges when cpha_i=1. The captured bits are placed into rx_data_o in the chosen bit order. For 8-bit frames, bits 15..8 of rx_data_o are 0.
- R6: With cs_hw_i=1, cs_n_o falls when the start is accepted, exactly one half-period before the first edge. It rises exactly one half-period after the last edge and is high whenever busy_o is low.
- R7: With cs_hw_i=0, cs_n_o stays high for the whole frame.
- R8: In transmit-only mode (dir_i=1), miso_i is ignored and rx_data_o is 0 after the frame.
- R9: In receive-only mode (dir_i=2), mosi_o stays 0 and mosi_oe_o stays low. mosi_oe_o is never high while busy_o is low.
- R10: A start_i pulse while busy_o is high is ignored: the frame in progress keeps its length and data, and no second frame follows.
- R11: done_o is high for exactly one clock, in the cycle in which busy_o first reads low. That cycle comes one half-period after the last edge, and rx_data_o is valid from then on.
- R12: Configuration inputs and tx_data_i are latched at start. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request, taken when not busy |
| dir_i | input | 2 | 0 full-duplex, 1 transmit-only, 2 receive-only (3 acts as 0) |
| wide_i | input | 1 | 0: 8-bit frame, 1: 16-bit frame |
| lsb_first_i | input | 1 | 1: bit 0 first, 0: top bit first |
| div_code_i | input | 3 | Divider code n, half-period 2^n clocks |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | 0: capture on first edge of a bit, 1: on second |
| cs_hw_i | input | 1 | 1: block drives chip select |
| tx_data_i | input | 16 | Word to send, low 8 bits used for 8-bit frames |
| miso_i | input | 1 | Serial data from the slave |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock pulse at frame end |
| rx_data_o | output | 16 | Received word, held until the next frame ends |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| mosi_oe_o | output | 1 | Output enable for mosi_o |
| cs_n_o | output | 1 | Chip select, active low |

## Verification
The bench builds the block with its default parameters: a 16-bit maximum frame, an 8-bit narrow frame and a 3-bit divider code. This lets it reach both frame widths and all eight divider ratios, including the fastest code 0, where each half-period is a single clock, and the slowest code 7, where it is 128 clocks. A slave model in the bench answers on the opposite clock edge for each of the four polarity and phase combinations. The bench also restarts and rewrites the configuration inputs in the middle of frames to exercise the latching and the ignored starts.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  parameter int unsigned CFG_DIV_W = 3;

  typedef enum logic [1:0] {
    DIR_FULL = 2'd0,
    DIR_TXO  = 2'd1,
    DIR_RXO  = 2'd2
  } dir_e;

  typedef struct packed {
    logic [1:0]           dir;
    logic                 wide;
    logic                 lsb_first;
    logic [CFG_DIV_W-1:0] div;
    logic                 cpol;
    logic                 cpha;
    logic                 cs_hw;
  } cfg_t;
endpackage

// File: rtl/spi_xfer_timer.sv
module spi_xfer_timer #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] code_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q, lim;

  // half-period minus one: 2^code - 1
  always_comb lim = ~({CNT_W{1'b1}} << code_i);

  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_xfer_shift.sv
module spi_xfer_shift #(
  parameter int MAX_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MAX_W-1:0] tx_i,
  input  logic             wide_i,
  input  logic             lsb_first_i,
  input  logic             shift_i,
  input  logic             sample_i,
  input  logic             capture_i,
  input  logic             miso_i,
  output logic             bit_o,
  output logic [MAX_W-1:0] rx_o
);
  localparam int IDX_W = $clog2(MAX_W);

  logic [MAX_W-1:0] tx_q, rx_q;
  logic [IDX_W-1:0] idx_q, last, pos;

  always_comb begin
    last = wide_i ? IDX_W'(MAX_W - 1) : IDX_W'(NARROW_W - 1);
    pos  = lsb_first_i ? idx_q : last - idx_q;
  end

  assign bit_o = tx_q[pos];
  assign rx_o  = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      tx_q  <= tx_i;
      rx_q  <= '0;
      idx_q <= '0;
    end else begin
      if (sample_i && capture_i) rx_q[pos] <= miso_i;
      if (shift_i && idx_q != last) idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int MAX_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [1:0]           dir_i,
  input  logic                 wide_i,
  input  logic                 lsb_first_i,
  input  logic [CFG_DIV_W-1:0] div_code_i,
  input  logic                 cpol_i,
  input  logic                 cpha_i,
  input  logic                 cs_hw_i,
  input  logic [MAX_W-1:0]     tx_data_i,
  input  logic                 miso_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [MAX_W-1:0]     rx_data_o,
  output logic                 sclk_o,
  output logic                 mosi_o,
  output logic                 mosi_oe_o,
  output logic                 cs_n_o
);
  localparam int PH_W = $clog2(2 * MAX_W + 2);

  cfg_t             cfg_q;
  logic             busy_q, done_q, sclk_q, cs_n_q;
  logic [PH_W-1:0]  ph_q, ph_nxt, nedge;
  logic [MAX_W-1:0] rx_data_q, rx_w;
  logic             accept, tick, edge_ev, fin, odd, sample_ev, shift_ev, tx_bit, drive;

  assign accept = start_i && !busy_q;

  spi_xfer_timer #(.DIV_W(CFG_DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .run_i  (busy_q),
    .code_i (cfg_q.div),
    .tick_o (tick)
  );

  // ph_nxt is the number of the edge (1..2N) or the trailing step (2N+1)
  always_comb begin
    ph_nxt    = ph_q + 1'b1;
    nedge     = cfg_q.wide ? PH_W'(2 * MAX_W) : PH_W'(2 * NARROW_W);
    edge_ev   = tick && (ph_nxt <= nedge);
    fin       = tick && (ph_nxt == nedge + 1'b1);
    odd       = ph_nxt[0];
    sample_ev = edge_ev && (cfg_q.cpha ? !odd : odd);
    shift_ev  = edge_ev && (cfg_q.cpha ? (odd && ph_nxt != PH_W'(1)) : !odd);
  end

  spi_xfer_shift #(.MAX_W(MAX_W), .NARROW_W(NARROW_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .tx_i        (tx_data_i),
    .wide_i      (cfg_q.wide),
    .lsb_first_i (cfg_q.lsb_first),
    .shift_i     (shift_ev),
    .sample_i    (sample_ev),
    .capture_i   (cfg_q.dir != DIR_TXO),
    .miso_i      (miso_i),
    .bit_o       (tx_bit),
    .rx_o        (rx_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      sclk_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      ph_q      <= '0;
      rx_data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        cfg_q  <= '{dir: dir_i, wide: wide_i, lsb_first: lsb_first_i, div: div_code_i,
                    cpol: cpol_i, cpha: cpha_i, cs_hw: cs_hw_i};
        busy_q <= 1'b1;
        ph_q   <= '0;
        sclk_q <= cpol_i;
        cs_n_q <= ~cs_hw_i;
      end else if (tick) begin
        ph_q <= ph_nxt;
        if (edge_ev) sclk_q <= ~sclk_q;
        if (fin) begin
          busy_q    <= 1'b0;
          cs_n_q    <= 1'b1;
          done_q    <= 1'b1;
          rx_data_q <= rx_w;
        end
      end
    end
  end

  assign drive     = busy_q && (cfg_q.dir != DIR_RXO);
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_data_o = rx_data_q;
  assign sclk_o    = sclk_q;
  assign cs_n_o    = cs_n_q;
  assign mosi_oe_o = drive;
  assign mosi_o    = drive && tx_bit;
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       sclk_o,
  input logic       cs_n_o,
  input logic       mosi_o,
  input logic       mosi_oe_o,
  input logic       cs_hw_q,
  input logic [1:0] dir_q
);
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> busy_o || done_o);

  assert_sclk_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_o) |-> busy_o);

  assert_cs_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_n_o);

  assert_sw_cs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !cs_hw_q |-> cs_n_o);

  assert_rx_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && dir_q == 2'd2 |-> !mosi_oe_o && !mosi_o);

  assert_oe_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mosi_oe_o |-> busy_o);
endmodule

bind spi_xfer_master spi_xfer_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .sclk_o    (sclk_o),
  .cs_n_o    (cs_n_o),
  .mosi_o    (mosi_o),
  .mosi_oe_o (mosi_oe_o),
  .cs_hw_q   (cfg_q.cs_hw),
  .dir_q     (cfg_q.dir)
);

// File: tb/sim_spi_xfer_master.sv
`timescale 1ns/1ps
module sim_spi_xfer_master;
  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [1:0]  dir_i = 2'd0;
  logic        wide_i = 1'b0, lsb_first_i = 1'b0, cpol_i = 1'b0, cpha_i = 1'b0, cs_hw_i = 1'b1;
  logic [2:0]  div_code_i = 3'd0;
  logic [15:0] tx_data_i = '0;
  logic        miso_i = 1'b0;
  logic        busy_o, done_o, sclk_o, mosi_o, mosi_oe_o, cs_n_o;
  logic [15:0] rx_data_o;

  always #10 clk_i = ~clk_i;

  spi_xfer_master u0 (.*);

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk_i) cyc++;

  // frame state the monitor works from
  int b_dir, b_wide, b_lsb, b_cpha, b_hw, b_h;
  logic [15:0] b_sw;
  int edges, scount, sidx, gap_err, rxo_err, sw_err, done_cnt, done_busy_err;
  int t_start, first_edge, last_edge, cs_rise, done_cyc;
  logic [15:0] mosi_cap;
  logic sclk_prev, cs_prev;
  int last_cpol = 0;

  function automatic int posf(int j, int wide, int lsb);
    int n = wide ? 16 : 8;
    return lsb ? j : n - 1 - j;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (sclk_o !== sclk_prev) begin
      int k, n;
      n = b_wide ? 16 : 8;
      k = edges + 1;
      if (edges == 0) first_edge = cyc;
      else if (cyc - last_edge != b_h) gap_err++;
      last_edge = cyc;
      edges = k;
      if (b_cpha ? (k % 2 == 0) : (k % 2 == 1)) begin
        if (scount < n) mosi_cap[posf(scount, b_wide, b_lsb)] = mosi_o;
        scount++;
      end
      if (b_cpha ? (k % 2 == 1 && k > 1) : (k % 2 == 0)) begin
        sidx++;
        if (sidx < n) miso_i = b_sw[posf(sidx, b_wide, b_lsb)];
      end
    end
    if (busy_o && b_dir == 2 && (mosi_oe_o || mosi_o)) rxo_err++;
    if (busy_o && !b_hw && !cs_n_o) sw_err++;
    if (!cs_prev && cs_n_o) cs_rise = cyc;
    if (done_o) begin
      done_cnt++;
      done_cyc = cyc;
      if (busy_o) done_busy_err++;
    end
    sclk_prev = sclk_o;
    cs_prev   = cs_n_o;
  end

  task automatic run_xfer(input int code, input int dir, input int wide, input int lsb,
                          input int cpol, input int cpha, input int hw,
                          input logic [15:0] tx, input logic [15:0] sw, input bit poke);
    int n, wait_n;
    logic [15:0] mask, exp_rx;
    n    = wide ? 16 : 8;
    mask = wide ? 16'hFFFF : 16'h00FF;
    @(posedge clk_i); #1;
    chk(sclk_o == last_cpol[0], "R2 idle level", sclk_o, last_cpol);
    b_dir = dir; b_wide = wide; b_lsb = lsb; b_cpha = cpha; b_hw = hw; b_h = 1 << code; b_sw = sw;
    dir_i = dir[1:0]; wide_i = wide[0]; lsb_first_i = lsb[0]; div_code_i = code[2:0];
    cpol_i = cpol[0]; cpha_i = cpha[0]; cs_hw_i = hw[0]; tx_data_i = tx;
    miso_i = sw[posf(0, wide, lsb)];
    start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    edges = 0; scount = 0; sidx = 0; gap_err = 0; rxo_err = 0; sw_err = 0;
    done_cnt = 0; done_busy_err = 0; mosi_cap = '0; first_edge = -1; last_edge = 0;
    cs_rise = -1; done_cyc = -1;
    sclk_prev = sclk_o; cs_prev = cs_n_o; t_start = cyc;
    chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
    chk(cs_n_o == !hw[0], "R6/R7 cs at start", cs_n_o, !hw[0]);
    if (poke) begin
      repeat (3) @(posedge clk_i);
      #1;
      // R12: scramble every configuration input mid-frame, R10: restart request
      dir_i = 2'(dir + 1); wide_i = ~wide_i; lsb_first_i = ~lsb_first_i;
      div_code_i = 3'(code + 3); cpol_i = ~cpol_i; cpha_i = ~cpha_i; cs_hw_i = ~cs_hw_i;
      tx_data_i = ~tx;
      start_i = 1'b1;
      @(posedge clk_i); #1;
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R10 start ignored while busy", busy_o, 1);
    end
    wait_n = 0;
    while (!done_o && wait_n < 40000) begin
      @(posedge clk_i); #1;
      wait_n++;
    end
    chk(wait_n < 40000, "R11 watchdog", wait_n, 40000);
    repeat (3) @(posedge clk_i);
    #1;
    exp_rx = (dir == 1) ? 16'h0 : (sw & mask);
    chk(edges == 2 * n, "R3 edge count", edges, 2 * n);
    chk(gap_err == 0, "R1 edge spacing", gap_err, 0);
    chk(first_edge - t_start == b_h, "R1 lead-in length", first_edge - t_start, b_h);
    chk(sclk_o == cpol[0], "R2 level after frame", sclk_o, cpol);
    if (dir != 2) chk(mosi_cap == (tx & mask), "R4 mosi bits", mosi_cap, tx & mask);
    if (dir == 1) chk(rx_data_o == 16'h0, "R8 rx zero in transmit-only", rx_data_o, 0);
    else          chk(rx_data_o == exp_rx, "R5 received word", rx_data_o, exp_rx);
    if (hw) chk(cs_rise - last_edge == b_h, "R6 cs trail", cs_rise - last_edge, b_h);
    else    chk(sw_err == 0 && cs_n_o, "R7 cs untouched", sw_err, 0);
    if (dir == 2) chk(rxo_err == 0, "R9 mosi quiet", rxo_err, 0);
    chk(done_cnt == 1 && done_busy_err == 0, "R11 done pulse", done_cnt, 1);
    chk(done_cyc - last_edge == b_h, "R11 done timing", done_cyc - last_edge, b_h);
    if (poke) chk(edges == 2 * n && (dir == 1 || rx_data_o == exp_rx), "R12 latched config",
                  rx_data_o, exp_rx);
    chk(!busy_o, "R10 no second frame", busy_o, 0);
    last_cpol = cpol;
  endtask

  initial begin
    void'($urandom(32'h5A17_C3E1));
    b_dir = 0; b_wide = 0; b_lsb = 0; b_cpha = 0; b_hw = 1; b_h = 1; b_sw = '0;
    edges = 0; scount = 0; sidx = 0; mosi_cap = '0; sclk_prev = 1'b0; cs_prev = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    chk(!busy_o && !done_o, "R11 reset idle", {busy_o, done_o}, 0);
    chk(cs_n_o && !sclk_o, "R6 reset cs/sclk", {cs_n_o, sclk_o}, 2);
    chk(!mosi_oe_o && rx_data_o == 0, "R9 reset outputs", {mosi_oe_o, rx_data_o}, 0);
    rst_ni = 1'b1;
    // directed corners
    run_xfer(0, 0, 0, 0, 0, 0, 1, 16'h00A5, 16'h003C, 0);
    run_xfer(7, 0, 1, 1, 1, 1, 1, 16'hC381, 16'h5EE7, 0);
    run_xfer(1, 1, 1, 0, 0, 1, 1, 16'hBEEF, 16'hFFFF, 0);
    run_xfer(2, 2, 0, 1, 1, 0, 1, 16'hFFFF, 16'h00C6, 0);
    run_xfer(0, 0, 1, 0, 1, 1, 0, 16'h8001, 16'h7FFE, 0);
    run_xfer(3, 0, 1, 0, 0, 0, 1, 16'h1234, 16'hA55A, 1);
    run_xfer(0, 2, 0, 0, 0, 1, 0, 16'h00FF, 16'h0081, 1);
    for (int i = 0; i < 40; i++) begin
      int code;
      code = (i % 10 == 9) ? int'($urandom_range(7, 5)) : int'($urandom_range(4, 0));
      run_xfer(code, int'($urandom_range(2, 0)), int'($urandom_range(1, 0)),
               int'($urandom_range(1, 0)), int'($urandom_range(1, 0)),
               int'($urandom_range(1, 0)), int'($urandom_range(1, 0)),
               16'($urandom), 16'($urandom), (i % 4 == 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule